// File: doc/BRIEF.md
# Spike-Rate Voting Classifier Readout

This block turns the spike trains of up to fifteen output channels of a spiking network into one class decision. Each channel has its own engine that counts the spikes arriving during a window of timing ticks. The window spans 1, 16 or 32 ticks. When the window closes, the count is divided by the window length with a right shift, which gives the average. That average is compared against a threshold that all channels share.

Among the channels whose average is strictly above the threshold, the one with the largest average wins. Its index is registered onto the readout output together with a valid flag, and both hold until the next window closes. The timing tick comes from one of two sources, chosen by a select input. The first is an external slow-clock enable pulse. The second is a pulse derived from input activity, which fires on every ACT_DIV-th clock cycle that carries at least one spike.

Top module: `spike_vote_readout`

## Requirements
- R1: While reset is asserted and after it is released, before the first window end, `winner_o` is 0, `winner_valid_o` is 0 and `frame_done_o` is 0.
- R2: `win_mode_i` selects the window length: 0 gives 1 tick, 1 gives 16 ticks, 2 gives 32 ticks, and 3 acts as 1 tick. A window ends on the tick that completes it. In the cycle after that tick, `frame_done_o` is high for exactly one cycle, and it is low in every other cycle.
- R3: Each channel count saturates at 2^CNT_W-1 and does not wrap.
- R4: A channel's average is its window count shifted right by 0, 4 or 5 bits for windows of 1, 16 or 32 ticks.
- R5: Only a channel whose average is strictly greater than `thresh_i` is eligible. When no channel is eligible, the result is index 0 with `winner_valid_o` 0.
- R6: The eligible channel with the largest average wins and its index (bit i of `spike_i` is channel i) is output with `winner_valid_o` 1. On equal averages the lowest index wins.
- R7: With `tick_sel_i` 0 the tick is `slow_tick_i`. With `tick_sel_i` 1, `slow_tick_i` is ignored and a tick occurs on every ACT_DIV-th cycle in which any `spike_i` bit is high, counted since reset.
- R8: `winner_o` and `winner_valid_o` change only in the cycle after a window end and hold otherwise.
- R9: A spike in the same cycle as the closing tick counts in the ending window. All counts restart from zero for the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spike_i | input | NUM_CH | One spike flag per channel per cycle |
| slow_tick_i | input | 1 | External slow timing tick enable |
| tick_sel_i | input | 1 | Tick source: 0 external, 1 activity-derived |
| win_mode_i | input | 2 | Window length code |
| thresh_i | input | CNT_W | Shared eligibility threshold on the average |
| winner_o | output | IDX_W | Index of the winning channel |
| winner_valid_o | output | 1 | A channel passed the threshold in the last window |
| frame_done_o | output | 1 | One-cycle pulse: result updated |

## Verification
The bench builds the block with all fifteen channels, a count width of 7 bits and an activity divider of 4. The narrow count saturates at 127 within a 32-tick window when ticks are spaced eight cycles apart, so clamping can be told apart from wrapping through the winner it produces. The small divider makes activity ticks frequent enough that windows of every length close many times within a short run. Mode changes in the middle of a window, threshold equality and ties are also reached.

// File: rtl/svr_pkg.sv
package svr_pkg;

   typedef enum logic [1:0] {
      WIN_ONE   = 2'd0,
      WIN_SIXTN = 2'd1,
      WIN_THRTW = 2'd2,
      WIN_ALT1  = 2'd3
   } win_mode_e;

   localparam int TICK_CNT_W = 6;

   function automatic logic [2:0] win_shift(input logic [1:0] mode);
      case (mode)
         WIN_SIXTN: win_shift = 3'd4;
         WIN_THRTW: win_shift = 3'd5;
         default:   win_shift = 3'd0;
      endcase
   endfunction

   function automatic logic [TICK_CNT_W-1:0] win_last(input logic [1:0] mode);
      case (mode)
         WIN_SIXTN: win_last = TICK_CNT_W'(15);
         WIN_THRTW: win_last = TICK_CNT_W'(31);
         default:   win_last = '0;
      endcase
   endfunction

endpackage

// File: rtl/svr_tick_gen.sv
module svr_tick_gen #(
   parameter int ACT_DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic any_spike,
   input  logic slow_tick,
   input  logic use_act,
   output logic tick
);
   logic act_tick;

   generate
      if (ACT_DIV == 1) begin : g_direct
         assign act_tick = any_spike;
      end else begin : g_divided
         localparam int AW = $clog2(ACT_DIV);
         localparam logic [AW-1:0] LAST = AW'(ACT_DIV - 1);
         logic [AW-1:0] act_cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               act_cnt <= '0;
            else if (any_spike)
               act_cnt <= (act_cnt == LAST) ? '0 : act_cnt + AW'(1);
         end

         assign act_tick = any_spike && (act_cnt == LAST);
      end
   endgenerate

   assign tick = use_act ? act_tick : slow_tick;

endmodule

// File: rtl/svr_chan_acc.sv
module svr_chan_acc #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             spike,
   input  logic             close_win,
   input  logic [2:0]       shift,
   output logic [CNT_W-1:0] avg
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] total;

   always_comb begin
      if (spike && cnt != CMAX)
         total = cnt + CNT_W'(1);
      else
         total = cnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (close_win)
         cnt <= '0;
      else
         cnt <= total;
   end

   assign avg = total >> shift;

endmodule

// File: rtl/svr_argmax.sv
module svr_argmax #(
   parameter int NUM_CH = 15,
   parameter int CNT_W  = 12,
   parameter int IDX_W  = 4
) (
   input  logic [NUM_CH*CNT_W-1:0] avg_flat,
   input  logic [CNT_W-1:0]        thresh,
   output logic [IDX_W-1:0]        best_idx,
   output logic                    best_found
);
   logic [CNT_W-1:0] s_val   [NUM_CH+1];
   logic [IDX_W-1:0] s_idx   [NUM_CH+1];
   logic             s_found [NUM_CH+1];

   assign s_val[0]   = '0;
   assign s_idx[0]   = '0;
   assign s_found[0] = 1'b0;

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_stage
         logic [CNT_W-1:0] v;
         logic             take;
         assign v    = avg_flat[i*CNT_W +: CNT_W];
         assign take = (v > thresh) && (!s_found[i] || v > s_val[i]);
         assign s_val[i+1]   = take ? v : s_val[i];
         assign s_idx[i+1]   = take ? IDX_W'(i) : s_idx[i];
         assign s_found[i+1] = s_found[i] | take;
      end
   endgenerate

   assign best_idx   = s_idx[NUM_CH];
   assign best_found = s_found[NUM_CH];

endmodule

// File: rtl/spike_vote_readout.sv
module spike_vote_readout #(
   parameter int NUM_CH  = 15,
   parameter int CNT_W   = 12,
   parameter int ACT_DIV = 8,
   localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] spike_i,
   input  logic              slow_tick_i,
   input  logic              tick_sel_i,
   input  logic [1:0]        win_mode_i,
   input  logic [CNT_W-1:0]  thresh_i,
   output logic [IDX_W-1:0]  winner_o,
   output logic              winner_valid_o,
   output logic              frame_done_o
);
   import svr_pkg::*;

   generate
      if (NUM_CH < 2 || NUM_CH > 15) begin : g_bad_ch
         $error("spike_vote_readout: NUM_CH must lie in 2..15");
      end
      if (CNT_W < 6) begin : g_bad_w
         $error("spike_vote_readout: CNT_W must be at least 6");
      end
      if (ACT_DIV < 1) begin : g_bad_div
         $error("spike_vote_readout: ACT_DIV must be positive");
      end
   endgenerate

   logic                  tick;
   logic                  win_end;
   logic [TICK_CNT_W-1:0] tick_cnt;
   logic [2:0]            shift;
   logic [NUM_CH*CNT_W-1:0] avg_flat;
   logic [IDX_W-1:0]      sel_idx;
   logic                  sel_found;

   svr_tick_gen #(.ACT_DIV(ACT_DIV)) u_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .any_spike (|spike_i),
      .slow_tick (slow_tick_i),
      .use_act   (tick_sel_i),
      .tick      (tick)
   );

   assign shift   = win_shift(win_mode_i);
   assign win_end = tick && (tick_cnt >= win_last(win_mode_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tick_cnt <= '0;
      else if (win_end)
         tick_cnt <= '0;
      else if (tick)
         tick_cnt <= tick_cnt + TICK_CNT_W'(1);
   end

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
         svr_chan_acc #(.CNT_W(CNT_W)) u_acc (
            .clk       (clk),
            .rst_n     (rst_n),
            .spike     (spike_i[c]),
            .close_win (win_end),
            .shift     (shift),
            .avg       (avg_flat[c*CNT_W +: CNT_W])
         );
      end
   endgenerate

   svr_argmax #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_pick (
      .avg_flat   (avg_flat),
      .thresh     (thresh_i),
      .best_idx   (sel_idx),
      .best_found (sel_found)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         winner_o       <= '0;
         winner_valid_o <= 1'b0;
         frame_done_o   <= 1'b0;
      end else begin
         frame_done_o <= win_end;
         if (win_end) begin
            winner_o       <= sel_found ? sel_idx : '0;
            winner_valid_o <= sel_found;
         end
      end
   end

endmodule

// File: rtl/svr_checker.sv
module svr_checker #(
   parameter int NUM_CH = 15,
   parameter int IDX_W  = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic [1:0]       win_mode_i,
   input logic [IDX_W-1:0] winner_o,
   input logic             winner_valid_o,
   input logic             frame_done_o
);
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_done_o |-> ($stable(winner_o) && $stable(winner_valid_o)));

   assert_idle_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !winner_valid_o |-> (winner_o == '0));

   assert_index_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, winner_o} < (IDX_W+1)'(NUM_CH)));

   assert_single_tick_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (win_mode_i == 2'd0 || win_mode_i == 2'd3)) |=> frame_done_o);

   assert_no_tick_no_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> !frame_done_o);

endmodule

bind spike_vote_readout svr_checker #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_svr_checker (
   .clk            (clk),
   .rst_n          (rst_n),
   .tick           (tick),
   .win_mode_i     (win_mode_i),
   .winner_o       (winner_o),
   .winner_valid_o (winner_valid_o),
   .frame_done_o   (frame_done_o)
);

// File: tb/spike_vote_readout_tb.sv
module spike_vote_readout_tb;
   localparam int NCH  = 15;
   localparam int CW   = 7;
   localparam int DIV  = 4;
   localparam int CMAX = (1 << CW) - 1;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] spike_i = '0;
   logic           slow_tick_i = 1'b0;
   logic           tick_sel_i = 1'b0;
   logic [1:0]     win_mode_i = 2'd0;
   logic [CW-1:0]  thresh_i = '0;
   logic [3:0]     winner_o;
   logic           winner_valid_o;
   logic           frame_done_o;

   int checks = 0;
   int errors = 0;
   int m_cnt [NCH];
   int m_act = 0;
   int m_tcnt = 0;
   int exp_w = 0;
   int exp_v = 0;
   int exp_d = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   spike_vote_readout #(.NUM_CH(NCH), .CNT_W(CW), .ACT_DIV(DIV)) u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .spike_i        (spike_i),
      .slow_tick_i    (slow_tick_i),
      .tick_sel_i     (tick_sel_i),
      .win_mode_i     (win_mode_i),
      .thresh_i       (thresh_i),
      .winner_o       (winner_o),
      .winner_valid_o (winner_valid_o),
      .frame_done_o   (frame_done_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // One cycle: drive at negedge, advance the model, sample at the next negedge.
   task automatic step(input logic [NCH-1:0] spk, input logic slow, input string tag);
      bit any, tk, wend;
      int len, sh, best, found, a;
      int tot [NCH];
      spike_i = spk;
      slow_tick_i = slow;
      any = |spk;
      tk  = tick_sel_i ? (any && m_act == DIV-1) : slow;
      if (any) m_act = (m_act == DIV-1) ? 0 : m_act + 1;
      len = (win_mode_i == 2'd1) ? 16 : (win_mode_i == 2'd2) ? 32 : 1;
      sh  = (win_mode_i == 2'd1) ? 4 : (win_mode_i == 2'd2) ? 5 : 0;
      for (int i = 0; i < NCH; i++) begin
         tot[i] = m_cnt[i] + int'(spk[i]);
         if (tot[i] > CMAX) tot[i] = CMAX;
      end
      wend = tk && (m_tcnt >= len-1);
      if (wend) begin
         best = 0; found = 0; exp_w = 0;
         for (int i = 0; i < NCH; i++) begin
            a = tot[i] >> sh;
            if (a > int'(thresh_i) && (found == 0 || a > best)) begin
               best = a; found = 1; exp_w = i;
            end
         end
         exp_v = found;
         exp_d = 1;
         for (int i = 0; i < NCH; i++) m_cnt[i] = 0;
         m_tcnt = 0;
      end else begin
         exp_d = 0;
         for (int i = 0; i < NCH; i++) m_cnt[i] = tot[i];
         if (tk) m_tcnt++;
      end
      @(posedge clk);
      @(negedge clk);
      check("R2 done", int'(frame_done_o), exp_d);
      check(wend ? tag : "R8 hold", int'(winner_o), exp_w);
      check(wend ? "R5 valid" : "R8 valid hold", int'(winner_valid_o), exp_v);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [NCH-1:0] s;
      for (int i = 0; i < NCH; i++) m_cnt[i] = 0;
      repeat (3) @(negedge clk);
      // R1: reset values
      check("R1 winner", int'(winner_o), 0);
      check("R1 valid", int'(winner_valid_o), 0);
      check("R1 done", int'(frame_done_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", int'(winner_valid_o), 0);

      // R6: single channel, one-tick window, spike on the closing tick (R9)
      step(15'h0008, 1'b1, "R6 single");
      // R6 tie between channels 5 and 9
      step(15'h0220, 1'b1, "R6 tie");
      // R9: a fresh window with no spikes has nothing to report
      step(15'h0000, 1'b1, "R9 cleared");
      // R5: average equal to the threshold is not enough
      thresh_i = 7'd1;
      step(15'h0004, 1'b1, "R5 equal");
      step(15'h0000, 1'b0, "R8 idle");
      thresh_i = 7'd0;

      // R4: 16-tick window, 15 spikes average to 0, 16 average to 1
      win_mode_i = 2'd1;
      for (int k = 0; k < 16; k++) begin
         s = '0; s[8] = 1'b1; s[7] = (k < 15);
         step(s, 1'b1, "R4 shift4");
      end

      // R3: 32 ticks spaced 8 cycles apart; ch0 clamps at 127, ch4 holds 96
      win_mode_i = 2'd2;
      for (int k = 0; k < 256; k++) begin
         s = '0; s[0] = (k < 200); s[4] = (k < 96);
         step(s, (k % 8) == 7, "R3 saturate");
      end

      // R2: code 3 acts as a single-tick window
      win_mode_i = 2'd3;
      step(15'h4000, 1'b1, "R2 mode3");

      // R7: activity ticks, external tick ignored
      win_mode_i = 2'd0;
      tick_sel_i = 1'b1;
      for (int k = 0; k < 12; k++) begin
         s = '0; s[6] = (k % 2 == 0);
         step(s, 1'b1, "R7 activity");
      end

      // Random phases
      void'($urandom(32'd20240611));
      for (int p = 0; p < 8; p++) begin
         int dens;
         win_mode_i = 2'($urandom_range(0, 3));
         tick_sel_i = 1'($urandom_range(0, 1));
         thresh_i   = 7'($urandom_range(0, 4));
         dens       = $urandom_range(1, 6);
         for (int k = 0; k < 500; k++) begin
            s = '0;
            for (int i = 0; i < NCH; i++)
               s[i] = ($urandom_range(0, 7) < dens) && ($urandom_range(0, NCH) >= i / 2);
            step(s, $urandom_range(0, 3) == 0, "R6 random");
         end
      end

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule